// File: doc/BRIEF.md
# SATA Port Control and Notification Registers

This block is the host-side register logic for a single SATA port. Software reaches it over a simple register bus with single-cycle writes and combinational reads. It holds a control word and a per-port notification word. The control word carries an interface power-management restriction, a speed cap and a detection command. It also has a power-state request field that acts only at the moment it is written. The notification word collects one bit per port-multiplier port.

The link layer reports each received Set Device Bits FIS on a one-cycle strobe. The strobe carries the notification flag, the interrupt flag and the 4-bit port-multiplier port number. A notifying FIS sets the matching notification bit. If the FIS also requests an interrupt and interrupts are enabled, a level interrupt is latched. It stays latched until software clears it. The detection command drives a hold-in-reset output and an offline output for the link. Notification bits are kept while the link is held in reset.

Top module: `sata_port_regs`

Word offsets: 0 is the control word, 1 is the notification word, 2 is the interrupt word. Any other offset reads zero.

## Requirements
- R1: After reset, every output is 0 and all three words read 0.
- R2: Writing the control word with bits 15:12 equal to 0001, 0010 or 0100 makes `pm_req` high for exactly one cycle. That cycle is the one following the write edge, and `pm_code` shows the written code during it. Otherwise `pm_req` is low and `pm_code` is 0000.
- R3: Any other value in control bits 15:12 produces no request. Bits 15:12 of the control word always read 0000.
- R4: Control bits 11:8 (power-management restriction) and 7:4 (speed cap) are stored. They drive `ipm_restrict` and `speed_cap` and read back in place. Control bits 31:16 are ignored on write and read 0.
- R5: While the stored detection field (control bits 3:0) equals 0001, `link_hold_reset` is high. It changes only when a later control write changes that field.
- R6: While the detection field equals 0100, `link_offline` is high. For every other value, including 0000, it is low.
- R7: A FIS strobe with the notification flag set sets the notification bit whose index equals the port number. With the flag clear, the strobe leaves the word unchanged.
- R8: Writing the notification word clears each bit 15:0 that is written as 1 and keeps the bits written as 0. Bits 31:16 read 0.
- R9: When a FIS set and a write-one-to-clear hit the same notification bit in one cycle, the bit ends up set.
- R10: Notification bits keep their values while the detection field holds the link in reset, and after it is released.
- R11: `irq` rises after a FIS that has both flags set while the enable bit is 1. A FIS without both flags, or one arriving while the enable bit is 0, leaves `irq` low. `irq` stays high until software writes 1 to interrupt-word bit 16.
- R12: Interrupt-word bit 0 is a read/write enable. Bit 16 reads the pending interrupt. Writing 0 to bit 16 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| sdb_valid | input | 1 | Set Device Bits FIS received this cycle |
| sdb_notify | input | 1 | Notification flag of the FIS |
| sdb_intr | input | 1 | Interrupt flag of the FIS |
| sdb_pmport | input | 4 | Port-multiplier port number of the FIS |
| pm_req | output | 1 | One-cycle power-state request |
| pm_code | output | 4 | Requested power state while `pm_req` is high |
| ipm_restrict | output | 4 | Power-management restriction code |
| speed_cap | output | 4 | Speed limit code |
| link_hold_reset | output | 1 | Hold the link in hard reset |
| link_offline | output | 1 | Interface disabled, PHY offline |
| irq | output | 1 | Level interrupt |

## Verification
The control word is written with each legal power-state code, with reserved codes, and with junk in the upper half. This separates a real one-shot request from a stored field, and a decoded code from a forwarded one. FIS strobes are sent with every combination of the two flags and with the enable both on and off. This shows whether the interrupt needs both flags and the enable, and whether the notification bit needs only its own flag. Clears that coincide with sets on the same bit and on different bits show the precedence rule. Strobes sent while the link is held in reset show that the notification word is independent of the detection command.

// File: rtl/sata_port_regs_pkg.sv
package sata_port_regs_pkg;

    localparam int REG_W   = 32;
    localparam int FIELD_W = 4;
    localparam int PMP_W   = 4;
    localparam int NBITS   = 1 << PMP_W;

    localparam int OFS_CTRL  = 0;
    localparam int OFS_NOTIF = 1;
    localparam int OFS_IRQ   = 2;

    localparam int IRQ_EN_BIT   = 0;
    localparam int IRQ_PEND_BIT = 16;

    typedef enum logic [FIELD_W-1:0] {
        PM_NONE    = 4'b0000,
        PM_PARTIAL = 4'b0001,
        PM_SLUMBER = 4'b0010,
        PM_ACTIVE  = 4'b0100
    } pm_code_e;

    localparam logic [FIELD_W-1:0] DET_HOLD    = 4'b0001;
    localparam logic [FIELD_W-1:0] DET_OFFLINE = 4'b0100;

    typedef struct packed {
        logic [FIELD_W-1:0] ipm;
        logic [FIELD_W-1:0] spd;
        logic [FIELD_W-1:0] det;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        logic             notify;
        logic             intr;
        logic [PMP_W-1:0] port;
    } sdb_evt_t;

    function automatic logic pm_is_legal(input logic [FIELD_W-1:0] c);
        return (c == PM_PARTIAL) || (c == PM_SLUMBER) || (c == PM_ACTIVE);
    endfunction

endpackage

// File: rtl/sata_ctrl_reg.sv
module sata_ctrl_reg
    import sata_port_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [15:0]          wdata,
    output ctrl_t                ctrl_q,
    output logic                 pm_req,
    output logic [FIELD_W-1:0]   pm_code
);

    logic [FIELD_W-1:0] pm_sel;
    assign pm_sel = wdata[15:12];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            pm_req  <= 1'b0;
            pm_code <= PM_NONE;
        end else begin
            pm_req  <= 1'b0;
            pm_code <= PM_NONE;
            if (wr) begin
                ctrl_q.ipm <= wdata[11:8];
                ctrl_q.spd <= wdata[7:4];
                ctrl_q.det <= wdata[3:0];
                if (pm_is_legal(pm_sel)) begin
                    pm_req  <= 1'b1;
                    pm_code <= pm_sel;
                end
            end
        end
    end

endmodule

// File: rtl/sata_notify_reg.sv
module sata_notify_reg
    import sata_port_regs_pkg::*;
#(
    parameter int NB = NBITS
) (
    input  logic          clk,
    input  logic          rst,
    input  sdb_evt_t      evt,
    input  logic          w1c_wr,
    input  logic [NB-1:0] w1c_mask,
    input  logic          irq_wr,
    input  logic          irq_en_wdata,
    input  logic          irq_clr_wdata,
    output logic [NB-1:0] notif_q,
    output logic          irq_en_q,
    output logic          irq_pend_q
);

    logic hit_notify;
    logic hit_irq;
    assign hit_notify = evt.valid && evt.notify;
    assign hit_irq    = hit_notify && evt.intr && irq_en_q;

    for (genvar i = 0; i < NB; i++) begin : g_bit
        logic set_i;
        logic clr_i;
        assign set_i = hit_notify && (int'(evt.port) == i);
        assign clr_i = w1c_wr && w1c_mask[i];
        always_ff @(posedge clk) begin
            if (rst)        notif_q[i] <= 1'b0;
            else if (set_i) notif_q[i] <= 1'b1;
            else if (clr_i) notif_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en_q   <= 1'b0;
            irq_pend_q <= 1'b0;
        end else begin
            if (irq_wr) irq_en_q <= irq_en_wdata;
            if (hit_irq)
                irq_pend_q <= 1'b1;
            else if (irq_wr && irq_clr_wdata)
                irq_pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/sata_port_regs.sv
module sata_port_regs
    import sata_port_regs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               sdb_valid,
    input  logic               sdb_notify,
    input  logic               sdb_intr,
    input  logic [PMP_W-1:0]   sdb_pmport,
    output logic               pm_req,
    output logic [FIELD_W-1:0] pm_code,
    output logic [FIELD_W-1:0] ipm_restrict,
    output logic [FIELD_W-1:0] speed_cap,
    output logic               link_hold_reset,
    output logic               link_offline,
    output logic               irq
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_NOTIF = ADDR_W'(OFS_NOTIF);
    localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(OFS_IRQ);

    logic            sel_ctrl, sel_notif, sel_irq;
    ctrl_t           ctrl_q;
    sdb_evt_t        evt;
    logic [NBITS-1:0] notif_q;
    logic            irq_en_q, irq_pend_q;
    logic [14:0]     unused_wdata_hi;

    assign unused_wdata_hi = reg_wdata[31:17];

    assign sel_ctrl  = (reg_addr == A_CTRL);
    assign sel_notif = (reg_addr == A_NOTIF);
    assign sel_irq   = (reg_addr == A_IRQ);

    assign evt = '{valid: sdb_valid, notify: sdb_notify, intr: sdb_intr, port: sdb_pmport};

    sata_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr && sel_ctrl),
        .wdata   (reg_wdata[15:0]),
        .ctrl_q  (ctrl_q),
        .pm_req  (pm_req),
        .pm_code (pm_code)
    );

    sata_notify_reg #(.NB(NBITS)) u_notify (
        .clk           (clk),
        .rst           (rst),
        .evt           (evt),
        .w1c_wr        (reg_wr && sel_notif),
        .w1c_mask      (reg_wdata[NBITS-1:0]),
        .irq_wr        (reg_wr && sel_irq),
        .irq_en_wdata  (reg_wdata[IRQ_EN_BIT]),
        .irq_clr_wdata (reg_wdata[IRQ_PEND_BIT]),
        .notif_q       (notif_q),
        .irq_en_q      (irq_en_q),
        .irq_pend_q    (irq_pend_q)
    );

    assign ipm_restrict    = ctrl_q.ipm;
    assign speed_cap       = ctrl_q.spd;
    assign link_hold_reset = (ctrl_q.det == DET_HOLD);
    assign link_offline    = (ctrl_q.det == DET_OFFLINE);
    assign irq             = irq_pend_q;

    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl) begin
            reg_rdata[11:8] = ctrl_q.ipm;
            reg_rdata[7:4]  = ctrl_q.spd;
            reg_rdata[3:0]  = ctrl_q.det;
        end else if (sel_notif) begin
            reg_rdata[NBITS-1:0] = notif_q;
        end else if (sel_irq) begin
            reg_rdata[IRQ_EN_BIT]   = irq_en_q;
            reg_rdata[IRQ_PEND_BIT] = irq_pend_q;
        end
    end

endmodule

// File: rtl/sata_port_regs_chk.sv
module sata_port_regs_chk
    import sata_port_regs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [REG_W-1:0]   reg_wdata,
    input logic               sdb_valid,
    input logic               sdb_notify,
    input logic               sdb_intr,
    input logic               pm_req,
    input logic [FIELD_W-1:0] pm_code,
    input logic               link_hold_reset,
    input logic               link_offline,
    input logic               irq,
    input logic [NBITS-1:0]   notif_q
);

    logic wr_ctrl, wr_notif, wr_irq_clr;
    assign wr_ctrl    = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
    assign wr_notif   = reg_wr && (reg_addr == ADDR_W'(OFS_NOTIF));
    assign wr_irq_clr = reg_wr && (reg_addr == ADDR_W'(OFS_IRQ)) && reg_wdata[IRQ_PEND_BIT];

    p_pm_single_r2: assert property (@(posedge clk) disable iff (rst)
        pm_req |=> !pm_req);

    p_pm_after_write_r2: assert property (@(posedge clk) disable iff (rst)
        pm_req |-> $past(wr_ctrl));

    p_pm_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
        pm_req |-> (pm_code == 4'b0001 || pm_code == 4'b0010 || pm_code == 4'b0100));

    p_pm_code_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !pm_req |-> (pm_code == 4'b0000));

    p_det_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> ($stable(link_hold_reset) && $stable(link_offline)));

    p_det_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(link_hold_reset && link_offline));

    p_notif_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (|(notif_q & ~$past(notif_q))) |-> $past(sdb_valid && sdb_notify));

    p_notif_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (|(~notif_q & $past(notif_q))) |-> $past(wr_notif));

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_irq_clr) |=> irq);

    p_irq_rise_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(sdb_valid && sdb_notify && sdb_intr));

endmodule

bind sata_port_regs sata_port_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .reg_wr          (reg_wr),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .sdb_valid       (sdb_valid),
    .sdb_notify      (sdb_notify),
    .sdb_intr        (sdb_intr),
    .pm_req          (pm_req),
    .pm_code         (pm_code),
    .link_hold_reset (link_hold_reset),
    .link_offline    (link_offline),
    .irq             (irq),
    .notif_q         (notif_q)
);

// File: tb/test_sata_port_regs.sv
module test_sata_port_regs;

    localparam int AW = 4;
    localparam int SEL_RD = 0, SEL_PM = 1, SEL_CFG = 2, SEL_LINK = 3, SEL_IRQ = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          sdb_valid = 1'b0, sdb_notify = 1'b0, sdb_intr = 1'b0;
    logic [3:0]    sdb_pmport = '0;
    logic          pm_req;
    logic [3:0]    pm_code, ipm_restrict, speed_cap;
    logic          link_hold_reset, link_offline, irq;

    always #10 clk = ~clk;

    sata_port_regs #(.ADDR_W(AW)) i_sata_port_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sdb_valid(sdb_valid), .sdb_notify(sdb_notify), .sdb_intr(sdb_intr),
        .sdb_pmport(sdb_pmport), .pm_req(pm_req), .pm_code(pm_code),
        .ipm_restrict(ipm_restrict), .speed_cap(speed_cap),
        .link_hold_reset(link_hold_reset), .link_offline(link_offline), .irq(irq)
    );

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    function automatic logic [31:0] observe(input int sel);
        case (sel)
            SEL_RD:   return reg_rdata;
            SEL_PM:   return {27'b0, pm_req, pm_code};
            SEL_CFG:  return {24'b0, ipm_restrict, speed_cap};
            SEL_LINK: return {30'b0, link_hold_reset, link_offline};
            default:  return {31'b0, irq};
        endcase
    endfunction

    // Monitor: pops expected items and compares them with what the ports show
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it  = q.pop_front();
                got = observe(it.sel);
                n_cmp++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FIL%s %s: got 0x%08h expected 0x%08h", "", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic push(input int sel, input logic [31:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic expect_rd(input int ofs, input logic [31:0] exp, input string tag);
        reg_addr = AW'(ofs);
        push(SEL_RD, exp, tag);
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int ofs, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = AW'(ofs); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic fis(input logic [3:0] port, input logic nf, input logic it);
        sdb_valid = 1'b1; sdb_notify = nf; sdb_intr = it; sdb_pmport = port;
        @(negedge clk);
        sdb_valid = 1'b0; sdb_notify = 1'b0; sdb_intr = 1'b0;
    endtask

    task automatic fis_and_clear(input logic [3:0] port, input logic [31:0] mask);
        sdb_valid = 1'b1; sdb_notify = 1'b1; sdb_intr = 1'b0; sdb_pmport = port;
        reg_wr = 1'b1; reg_addr = AW'(1); reg_wdata = mask;
        @(negedge clk);
        sdb_valid = 1'b0; sdb_notify = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        push(SEL_PM, 0, "R1 pm");
        push(SEL_CFG, 0, "R1 cfg");
        push(SEL_LINK, 0, "R1 link");
        push(SEL_IRQ, 0, "R1 irq");
        expect_rd(0, 32'h0, "R1 ctrl read");
        expect_rd(1, 32'h0, "R1 notif read");
        expect_rd(2, 32'h0, "R1 irq read");

        // R2 partial request, R4 fields stored
        wr(0, 32'h0000_1210);
        push(SEL_PM, 32'h11, "R2 partial pulse");
        push(SEL_CFG, 32'h21, "R4 ipm/spd out");
        expect_rd(0, 32'h0000_0210, "R3 R4 ctrl readback");
        push(SEL_PM, 32'h00, "R2 pulse ends");
        tick();
        wr(0, 32'h0000_2000);
        push(SEL_PM, 32'h12, "R2 slumber pulse");
        push(SEL_CFG, 32'h00, "R4 fields rewritten");
        tick();
        wr(0, 32'h0000_4000);
        push(SEL_PM, 32'h14, "R2 active pulse");
        tick();
        push(SEL_PM, 32'h00, "R2 pulse ends after active");
        tick();

        // R3 reserved codes, R4 upper bits
        wr(0, 32'hFFFF_3000);
        push(SEL_PM, 32'h00, "R3 code 0011 ignored");
        expect_rd(0, 32'h0, "R4 upper bits ignored");
        wr(0, 32'h0000_8033);
        push(SEL_PM, 32'h00, "R3 code 1000 ignored");
        push(SEL_CFG, 32'h03, "R4 spd=3 stored");
        expect_rd(0, 32'h0000_0033, "R3 pm field reads zero");

        // R5 hold, R10 notification during hold
        wr(0, 32'h0000_0001);
        push(SEL_LINK, 32'h2, "R5 hold asserted");
        tick();
        tick();
        push(SEL_LINK, 32'h2, "R5 hold persists");
        fis(4'd5, 1'b1, 1'b0);
        expect_rd(1, 32'h0000_0020, "R7 R10 set during hold");
        wr(0, 32'h0000_0004);
        push(SEL_LINK, 32'h1, "R6 offline");
        expect_rd(1, 32'h0000_0020, "R10 survives release");
        wr(0, 32'h0000_0000);
        push(SEL_LINK, 32'h0, "R6 det 0000 no action");
        tick();

        // R7 notify flag required
        fis(4'd3, 1'b0, 1'b0);
        expect_rd(1, 32'h0000_0020, "R7 notify=0 ignored");
        fis(4'd15, 1'b1, 1'b0);
        expect_rd(1, 32'h0000_8020, "R7 port 15 set");

        // R8 write-one-to-clear
        wr(1, 32'hFFFF_0020);
        expect_rd(1, 32'h0000_8000, "R8 w1c bit5, upper zero");
        wr(1, 32'h0000_0000);
        expect_rd(1, 32'h0000_8000, "R8 zero write keeps");

        // R9 set wins
        fis_and_clear(4'd15, 32'h0000_8000);
        expect_rd(1, 32'h0000_8000, "R9 set wins same bit");
        fis_and_clear(4'd2, 32'h0000_8000);
        expect_rd(1, 32'h0000_0004, "R9 different bits");

        // R11 / R12 interrupt
        fis(4'd1, 1'b1, 1'b1);
        push(SEL_IRQ, 0, "R11 disabled no irq");
        expect_rd(2, 32'h0, "R12 nothing pending");
        wr(2, 32'h0000_0001);
        expect_rd(2, 32'h0000_0001, "R12 enable readback");
        fis(4'd0, 1'b0, 1'b1);
        push(SEL_IRQ, 0, "R11 notify=0 no irq");
        tick();
        fis(4'd0, 1'b1, 1'b0);
        push(SEL_IRQ, 0, "R11 intr=0 no irq");
        expect_rd(1, 32'h0000_0007, "R7 bits 0,1,2");
        fis(4'd9, 1'b1, 1'b1);
        push(SEL_IRQ, 1, "R11 irq raised");
        expect_rd(2, 32'h0001_0001, "R12 pending bit");
        tick();
        tick();
        push(SEL_IRQ, 1, "R11 irq level held");
        tick();
        wr(2, 32'h0000_0001);
        push(SEL_IRQ, 1, "R12 bit16=0 keeps irq");
        tick();
        wr(2, 32'h0001_0001);
        push(SEL_IRQ, 0, "R11 irq cleared");
        expect_rd(2, 32'h0000_0001, "R12 enable kept after clear");
        tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule